// File: doc/BRIEF.md
# B-Channel Timeslot Loopback Controller

This block joins a serial time-division port to the byte-wide transmit and receive paths of a line transceiver. Each frame opens with a one-bit frame-sync pulse. Two 8-bit bearer channels follow it in fixed slots, MSB first: B1 in bit periods 1 to 8 and B2 in bit periods 9 to 16. A bit-clock enable qualifies every bit period. Serial input is sampled on the enabled clock of its own bit period. Serial output moves to the next bit on that same enabled clock.

A 4-bit control register chooses a loopback mode for each channel. In transparent loopback, the byte received in a channel's slot is returned in the same slot of the next frame, and the line side still transmits it. Non-transparent loopback returns the byte in the same way but sends idle all-ones to the line side. With no loopback, line receive bytes go out on the serial port and serial input bytes go to the line. A software reset, a return-to-normal command or a hardware reset clears the control bits. The controls behave the same in network-side and terminal-side operation.

Top module: `bchan_loopback`

## Requirements
- R1: The control register `ctrl_wdata` is written by `ctrl_we` and reads back on `ctrl_rdata` on the next clock. Its bit meanings are: bit 3 B1 transparent, bit 2 B1 non-transparent, bit 1 B2 transparent, bit 0 B2 non-transparent.
- R2: With a channel's two control bits at 0, the line receive byte for that channel goes out MSB first in its slot. The byte is sampled on the frame-sync bit: B1 from `line_rx_data[15:8]`, B2 from `line_rx_data[7:0]`. The serial input byte of that slot goes to the line unchanged.
- R3: Serial output bits for B1 appear in bit periods 1 to 8 after the sync bit, and bits for B2 appear in periods 9 to 16. `ser_oe` is 1 only in those periods. `ser_out` is 1 whenever `ser_oe` is 0.
- R4: With only the transparent bit set, a channel's slot carries the serial input byte of that channel from the previous frame. The line transmit byte is the current input byte, unchanged.
- R5: With only the non-transparent bit set, the slot is looped back as in R4, and the line transmit byte for that channel is 8'hFF.
- R6: With both bits of one channel set, that channel behaves as in R5.
- R7: Each slot yields a one-clock `line_tx_valid` pulse in the clock after its last bit is sampled. `line_tx_chan` is 0 for B1 and 1 for B2.
- R8: `sw_reset` clears all four control bits on the next clock, and it wins over a write in the same clock.
- R9: `rtn_normal` clears all four control bits on the next clock, and it wins over a write in the same clock.
- R10: Asserting `rst_n` low clears the control bits at once and forces `ser_oe` to 0, `ser_out` to 1 and `line_tx_valid` to 0. The loopback byte store also clears, so the first looped frame after reset returns 8'h00.
- R11: Clocks with `bit_en` at 0 do not advance the frame or change the serial output. A frame stretched by such clocks gives the same results as one without them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asserted asynchronously, released synchronously inside the block |
| sw_reset | input | 1 | Software reset pulse for the control bits |
| rtn_normal | input | 1 | Return-to-normal command pulse |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 4 | Control register write data |
| ctrl_rdata | output | 4 | Control register contents |
| bit_en | input | 1 | Bit-clock enable, one clock per bit period |
| fsync | input | 1 | Frame sync, high for the enabled clock of bit period 0 |
| ser_in | input | 1 | Serial port input data |
| ser_out | output | 1 | Serial port output data |
| ser_oe | output | 1 | Serial output drive enable |
| line_rx_data | input | 16 | Line receive bytes, B1 high and B2 low |
| line_tx_data | output | 8 | Line transmit byte |
| line_tx_valid | output | 1 | Line transmit byte strobe |
| line_tx_chan | output | 1 | Channel of the line transmit byte |

## Verification
The serial output for bit period k is registered on the enabled clock of period k-1, so the bench reads it at the falling edge after that enable. A looped byte is due one whole frame after it was sent, so the bench's model keeps the previous frame's input bytes. Each line transmit strobe is due exactly one clock after the enable of bit 8 or bit 16, so the bench samples it at the falling edge that follows, and samples again one clock later to confirm the pulse has dropped. Control clears are due one clock after the command, and a hardware reset takes effect at once; the bench checks both while the frame is idle.

// File: rtl/bchan_pkg.sv
package bchan_pkg;

  typedef enum logic [1:0] {
    LB_OFF      = 2'd0,
    LB_TRANS    = 2'd1,
    LB_NONTRANS = 2'd2
  } lb_mode_e;

  // non-transparent takes priority when both bits of a channel are set
  function automatic lb_mode_e decode_mode(input logic trans, input logic nontrans);
    if (nontrans)   return LB_NONTRANS;
    else if (trans) return LB_TRANS;
    else            return LB_OFF;
  endfunction

endpackage

// File: rtl/bchan_frame_timer.sv
module bchan_frame_timer #(
  parameter int FRAME_LAST = 16,
  parameter int POS_W      = 5
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             bit_en,
  input  logic             fsync,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] nx_pos
);

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_d;

  // index 0 means idle or sync bit; 1..FRAME_LAST are slot bits
  always_comb begin
    pos_d = pos_q;
    if (bit_en) begin
      if (fsync)
        pos_d = POS_W'(1);
      else if (pos_q != '0 && pos_q < POS_W'(FRAME_LAST))
        pos_d = pos_q + POS_W'(1);
      else
        pos_d = '0;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) pos_q <= '0;
    else if (bit_en) pos_q <= pos_d;
  end

  assign pos    = pos_q;
  assign nx_pos = pos_d;

endmodule

// File: rtl/bchan_ctrl_reg.sv
module bchan_ctrl_reg #(
  parameter int CTRL_W = 4
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              sw_reset,
  input  logic              rtn_normal,
  output logic [CTRL_W-1:0] ctrl
);

  logic [CTRL_W-1:0] ctrl_q;
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;

  assign ctrl_en = we | sw_reset | rtn_normal;

  always_comb begin
    if (sw_reset || rtn_normal) ctrl_d = '0;
    else                        ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  assign ctrl = ctrl_q;

endmodule

// File: rtl/bchan_chan_path.sv
module bchan_chan_path
  import bchan_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CH_IDX = 0,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              bit_en,
  input  logic              fsync,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  nx_pos,
  input  logic              ser_in,
  input  logic              lb_trans,
  input  logic              lb_nontrans,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_valid,
  output logic              out_bit,
  output logic              out_active
);

  localparam int FIRST = CH_IDX * BYTE_W + 1;
  localparam int LAST  = (CH_IDX + 1) * BYTE_W;
  localparam int IW    = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;

  lb_mode_e mode;
  logic     in_cur;
  logic     at_last;
  logic     frame_start;
  logic [BYTE_W-1:0] shift_q, shift_d;
  logic [BYTE_W-1:0] cap_q, cap_d;
  logic [BYTE_W-1:0] obuf_q, obuf_d;
  logic [BYTE_W-1:0] tx_byte_q, tx_byte_d;
  logic              tx_valid_q, tx_valid_d;
  logic [BYTE_W-1:0] full_byte;
  logic [BYTE_W-1:0] out_src;
  logic [IW-1:0]     bidx;

  assign mode        = decode_mode(lb_trans, lb_nontrans);
  assign in_cur      = (pos >= POS_W'(FIRST)) && (pos <= POS_W'(LAST));
  assign at_last     = bit_en && (pos == POS_W'(LAST));
  assign frame_start = bit_en && fsync;
  assign full_byte   = {shift_q[BYTE_W-2:0], ser_in};

  // next-state for capture, loopback store, line byte and output buffer
  always_comb begin
    shift_d    = shift_q;
    cap_d      = cap_q;
    tx_byte_d  = tx_byte_q;
    tx_valid_d = 1'b0;
    obuf_d     = obuf_q;
    if (bit_en && in_cur)
      shift_d = full_byte;
    if (at_last) begin
      cap_d      = full_byte;
      tx_byte_d  = (mode == LB_NONTRANS) ? {BYTE_W{1'b1}} : full_byte;
      tx_valid_d = 1'b1;
    end
    if (frame_start)
      obuf_d = (mode == LB_OFF) ? rx_byte : cap_q;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      shift_q    <= '0;
      cap_q      <= '0;
      tx_byte_q  <= '0;
      tx_valid_q <= 1'b0;
      obuf_q     <= '0;
    end else begin
      tx_valid_q <= tx_valid_d;
      if (bit_en) begin
        shift_q <= shift_d;
        cap_q   <= cap_d;
        obuf_q  <= obuf_d;
      end
      if (at_last) tx_byte_q <= tx_byte_d;
    end
  end

  // bit selection for the next bit period
  assign out_active = (nx_pos >= POS_W'(FIRST)) && (nx_pos <= POS_W'(LAST));
  assign out_src    = frame_start ? obuf_d : obuf_q;
  assign bidx       = IW'(BYTE_W - 1) - IW'(nx_pos - POS_W'(FIRST));
  assign out_bit    = out_src[bidx];

  assign tx_byte  = tx_byte_q;
  assign tx_valid = tx_valid_q;

endmodule

// File: rtl/bchan_loopback.sv
module bchan_loopback #(
  parameter int BYTE_W = 8,
  parameter int NUM_CH = 2,
  localparam int CTRL_W = 2 * NUM_CH,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_reset,
  input  logic                     rtn_normal,
  input  logic                     ctrl_we,
  input  logic [CTRL_W-1:0]        ctrl_wdata,
  output logic [CTRL_W-1:0]        ctrl_rdata,
  input  logic                     bit_en,
  input  logic                     fsync,
  input  logic                     ser_in,
  output logic                     ser_out,
  output logic                     ser_oe,
  input  logic [NUM_CH*BYTE_W-1:0] line_rx_data,
  output logic [BYTE_W-1:0]        line_tx_data,
  output logic                     line_tx_valid,
  output logic [CH_W-1:0]          line_tx_chan
);

  localparam int FRAME_LAST = NUM_CH * BYTE_W;
  localparam int POS_W      = $clog2(FRAME_LAST + 1);

  logic rst_meta, rst_sync;
  logic [CTRL_W-1:0] ctrl;
  logic [POS_W-1:0]  pos, nx_pos;
  logic [NUM_CH-1:0] ch_valid, ch_bit, ch_active;
  logic [BYTE_W-1:0] ch_byte [NUM_CH];
  logic ser_out_q, ser_out_d, ser_oe_q, ser_oe_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  bchan_ctrl_reg #(.CTRL_W(CTRL_W)) u_ctrl (
    .clk        (clk),
    .arst_n     (rst_sync),
    .we         (ctrl_we),
    .wdata      (ctrl_wdata),
    .sw_reset   (sw_reset),
    .rtn_normal (rtn_normal),
    .ctrl       (ctrl)
  );

  bchan_frame_timer #(.FRAME_LAST(FRAME_LAST), .POS_W(POS_W)) u_timer (
    .clk    (clk),
    .arst_n (rst_sync),
    .bit_en (bit_en),
    .fsync  (fsync),
    .pos    (pos),
    .nx_pos (nx_pos)
  );

  // channel c: transparent bit at 2*(NUM_CH-1-c)+1, non-transparent just below
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int NT_BIT = 2 * (NUM_CH - 1 - c);
    localparam int RX_LO  = (NUM_CH - 1 - c) * BYTE_W;
    bchan_chan_path #(.BYTE_W(BYTE_W), .CH_IDX(c), .POS_W(POS_W)) u_path (
      .clk         (clk),
      .arst_n      (rst_sync),
      .bit_en      (bit_en),
      .fsync       (fsync),
      .pos         (pos),
      .nx_pos      (nx_pos),
      .ser_in      (ser_in),
      .lb_trans    (ctrl[NT_BIT+1]),
      .lb_nontrans (ctrl[NT_BIT]),
      .rx_byte     (line_rx_data[RX_LO +: BYTE_W]),
      .tx_byte     (ch_byte[c]),
      .tx_valid    (ch_valid[c]),
      .out_bit     (ch_bit[c]),
      .out_active  (ch_active[c])
    );
  end

  always_comb begin
    ser_out_d = ser_out_q;
    ser_oe_d  = ser_oe_q;
    if (bit_en) begin
      ser_oe_d  = |ch_active;
      ser_out_d = |ch_active ? |(ch_bit & ch_active) : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      ser_out_q <= 1'b1;
      ser_oe_q  <= 1'b0;
    end else if (bit_en) begin
      ser_out_q <= ser_out_d;
      ser_oe_q  <= ser_oe_d;
    end
  end

  // slots never overlap, so at most one channel strobes per clock
  always_comb begin
    line_tx_valid = 1'b0;
    line_tx_data  = '0;
    line_tx_chan  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_valid[c]) begin
        line_tx_valid = 1'b1;
        line_tx_data  = ch_byte[c];
        line_tx_chan  = CH_W'(c);
      end
    end
  end

  assign ctrl_rdata = ctrl;
  assign ser_out    = ser_out_q;
  assign ser_oe     = ser_oe_q;

endmodule

// File: rtl/bchan_loopback_chk.sv
module bchan_loopback_chk #(
  parameter int BYTE_W = 8,
  parameter int NUM_CH = 2,
  parameter int CTRL_W = 4,
  parameter int CH_W   = 1
) (
  input logic              clk,
  input logic              arst_n,
  input logic              sw_reset,
  input logic              rtn_normal,
  input logic              ctrl_we,
  input logic [CTRL_W-1:0] ctrl_wdata,
  input logic [CTRL_W-1:0] ctrl_rdata,
  input logic              bit_en,
  input logic              ser_out,
  input logic              ser_oe,
  input logic [BYTE_W-1:0] line_tx_data,
  input logic              line_tx_valid,
  input logic [CH_W-1:0]   line_tx_chan
);

  // R1: a plain write is readable on the next clock
  p_write_back_r1: assert property (@(posedge clk) disable iff (!arst_n)
    (ctrl_we && !sw_reset && !rtn_normal) |=> (ctrl_rdata == $past(ctrl_wdata)));

  // R3: undriven output idles high
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !ser_oe |-> ser_out);

  // R5: first channel non-transparent gives idle ones on the line
  p_idle_ones_first_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (line_tx_valid && line_tx_chan == '0 && $past(ctrl_rdata[CTRL_W-2]))
      |-> (line_tx_data == {BYTE_W{1'b1}}));

  // R5: last channel non-transparent gives idle ones on the line
  p_idle_ones_last_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (line_tx_valid && line_tx_chan == CH_W'(NUM_CH - 1) && $past(ctrl_rdata[0]))
      |-> (line_tx_data == {BYTE_W{1'b1}}));

  // R7: the line strobe lasts a single clock
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (!arst_n)
    line_tx_valid |=> !line_tx_valid);

  // R8: software reset clears all control bits
  p_sw_clear_r8: assert property (@(posedge clk) disable iff (!arst_n)
    sw_reset |=> (ctrl_rdata == '0));

  // R9: return-to-normal clears all control bits
  p_rtn_clear_r9: assert property (@(posedge clk) disable iff (!arst_n)
    rtn_normal |=> (ctrl_rdata == '0));

  // R11: a disabled bit clock leaves the serial output unchanged
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!arst_n)
    !bit_en |=> ($stable(ser_out) && $stable(ser_oe)));

endmodule

bind bchan_loopback bchan_loopback_chk #(
  .BYTE_W(BYTE_W), .NUM_CH(NUM_CH), .CTRL_W(CTRL_W), .CH_W(CH_W)
) u_chk (
  .clk           (clk),
  .arst_n        (rst_sync),
  .sw_reset      (sw_reset),
  .rtn_normal    (rtn_normal),
  .ctrl_we       (ctrl_we),
  .ctrl_wdata    (ctrl_wdata),
  .ctrl_rdata    (ctrl_rdata),
  .bit_en        (bit_en),
  .ser_out       (ser_out),
  .ser_oe        (ser_oe),
  .line_tx_data  (line_tx_data),
  .line_tx_valid (line_tx_valid),
  .line_tx_chan  (line_tx_chan)
);

// File: tb/sim_bchan_loopback.sv
`timescale 1ns/1ps
module sim_bchan_loopback;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 1'b0, rtn_normal = 1'b0, ctrl_we = 1'b0;
  logic [3:0]  ctrl_wdata = '0;
  logic [3:0]  ctrl_rdata;
  logic        bit_en = 1'b0, fsync = 1'b0, ser_in = 1'b0;
  logic        ser_out, ser_oe;
  logic [15:0] line_rx_data = '0;
  logic [7:0]  line_tx_data;
  logic        line_tx_valid;
  logic [0:0]  line_tx_chan;

  int total = 0;
  int bad   = 0;
  logic [3:0] mdl_ctrl = '0;
  logic [7:0] prev1 = '0, prev2 = '0;

  always #4 clk = ~clk;

  bchan_loopback u0 (
    .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .rtn_normal(rtn_normal),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .ctrl_rdata(ctrl_rdata),
    .bit_en(bit_en), .fsync(fsync), .ser_in(ser_in), .ser_out(ser_out),
    .ser_oe(ser_oe), .line_rx_data(line_rx_data), .line_tx_data(line_tx_data),
    .line_tx_valid(line_tx_valid), .line_tx_chan(line_tx_chan)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(input logic t, input logic n);
    if (t && n) return "R6";
    if (n)      return "R5";
    if (t)      return "R4";
    return "R2";
  endfunction

  task automatic write_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
    mdl_ctrl = v;
    chk("R1 control readback", {4'h0, ctrl_rdata}, {4'h0, v});
  endtask

  // one frame: sync bit then 16 slot bits; gap adds a disabled clock after each bit
  task automatic run_frame(input logic [7:0] in1, input logic [7:0] in2,
                           input logic [7:0] rx1, input logic [7:0] rx2,
                           input bit gap, input string extra);
    logic [7:0] got1, got2, eo1, eo2, et1, et2;
    logic       oe_ok, v1, v2, c1, c2, drop_ok;
    logic [7:0] tx1, tx2;
    string t1, t2;
    got1 = '0; got2 = '0; oe_ok = 1'b1; drop_ok = 1'b1;
    v1 = 0; v2 = 0; c1 = 0; c2 = 1; tx1 = '0; tx2 = '0;
    eo1 = (mdl_ctrl[3] | mdl_ctrl[2]) ? prev1 : rx1;
    eo2 = (mdl_ctrl[1] | mdl_ctrl[0]) ? prev2 : rx2;
    et1 = mdl_ctrl[2] ? 8'hFF : in1;
    et2 = mdl_ctrl[0] ? 8'hFF : in2;
    t1 = {mode_tag(mdl_ctrl[3], mdl_ctrl[2]), extra};
    t2 = {mode_tag(mdl_ctrl[1], mdl_ctrl[0]), extra};
    line_rx_data = {rx1, rx2};
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk);
      bit_en = 1'b1;
      fsync  = (i == 0);
      ser_in = (i == 0) ? 1'b0 : (i <= 8) ? in1[8-i] : in2[16-i];
      @(negedge clk);
      bit_en = 1'b0; fsync = 1'b0;
      if (i <= 15) begin
        if (!ser_oe) oe_ok = 1'b0;
        if (i + 1 <= 8) got1[7-i] = ser_out; else got2[15-i] = ser_out;
      end else if (ser_oe || !ser_out) oe_ok = 1'b0;
      if (i == 8)  begin v1 = line_tx_valid; c1 = line_tx_chan[0]; tx1 = line_tx_data; end
      if (i == 16) begin v2 = line_tx_valid; c2 = line_tx_chan[0]; tx2 = line_tx_data; end
      if (i != 8 && i != 16 && line_tx_valid) drop_ok = 1'b0;
      if (gap) begin
        @(negedge clk);
        if (line_tx_valid) drop_ok = 1'b0;
      end
    end
    @(negedge clk);
    if (line_tx_valid) drop_ok = 1'b0;
    chk({t1, " B1 serial out"}, got1, eo1);
    chk({t2, " B2 serial out"}, got2, eo2);
    chk({t1, " B1 line tx"}, tx1, et1);
    chk({t2, " B2 line tx"}, tx2, et2);
    chk("R3 output enable window", {7'h0, oe_ok}, 8'h01);
    chk("R7 strobe/chan", {4'h0, v1, c1, v2, c2}, 8'h0B);
    chk("R7 strobe one clock", {7'h0, drop_ok}, 8'h01);
    prev1 = in1; prev2 = in2;
  endtask

  task automatic t_reset_state;
    chk("R10 ctrl after reset", {4'h0, ctrl_rdata}, 8'h00);
    chk("R10 oe/out/valid after reset", {5'h0, ser_oe, ser_out, line_tx_valid}, 8'h02);
  endtask

  task automatic t_normal;
    write_ctrl(4'h0);
    run_frame(8'hA5, 8'h3C, 8'h81, 8'h7E, 0, " normal");
    run_frame(8'h00, 8'hFF, 8'hFF, 8'h00, 0, " normal");
  endtask

  task automatic t_single_modes;
    write_ctrl(4'b1000);  // B1 transparent
    run_frame(8'h12, 8'h34, 8'h56, 8'h78, 0, " B1 trans");
    run_frame(8'h9A, 8'hBC, 8'hDE, 8'hF0, 0, " B1 trans");
    write_ctrl(4'b0001);  // B2 non-transparent
    run_frame(8'h11, 8'h22, 8'h33, 8'h44, 0, " B2 nontrans");
    write_ctrl(4'b0110);  // B1 non-transparent, B2 transparent
    run_frame(8'h5A, 8'hC3, 8'h0F, 8'hF0, 0, " mixed");
    write_ctrl(4'b1111);  // both bits per channel
    run_frame(8'h66, 8'h99, 8'h01, 8'h02, 0, " both set");
  endtask

  task automatic t_all_modes;
    for (int m = 0; m < 16; m++) begin
      write_ctrl(m[3:0]);
      run_frame(8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 0, " sweep");
    end
  endtask

  task automatic t_stall;
    write_ctrl(4'b1001);
    run_frame(8'hC7, 8'h38, 8'hE1, 8'h1E, 1, " R11 stalled");
    run_frame(8'h4B, 8'hB4, 8'h2D, 8'hD2, 1, " R11 stalled");
  endtask

  task automatic t_clears;
    write_ctrl(4'hF);
    @(negedge clk); sw_reset = 1'b1; ctrl_we = 1'b1; ctrl_wdata = 4'hA;
    @(negedge clk); sw_reset = 1'b0; ctrl_we = 1'b0;
    mdl_ctrl = 4'h0;
    chk("R8 sw_reset clears over write", {4'h0, ctrl_rdata}, 8'h00);
    run_frame(8'h01, 8'h80, 8'hAA, 8'h55, 0, " R8 after clear");
    write_ctrl(4'hF);
    @(negedge clk); rtn_normal = 1'b1; ctrl_we = 1'b1; ctrl_wdata = 4'h5;
    @(negedge clk); rtn_normal = 1'b0; ctrl_we = 1'b0;
    mdl_ctrl = 4'h0;
    chk("R9 return-to-normal clears over write", {4'h0, ctrl_rdata}, 8'h00);
    run_frame(8'hF1, 8'h1F, 8'hCC, 8'h33, 0, " R9 after clear");
  endtask

  task automatic t_hw_reset;
    write_ctrl(4'hA);
    run_frame(8'h77, 8'h88, 8'h00, 8'h00, 0, " pre-reset");
    #1 rst_n = 1'b0;
    #2;
    chk("R10 async clear ctrl", {4'h0, ctrl_rdata}, 8'h00);
    chk("R10 async clear outputs", {5'h0, ser_oe, ser_out, line_tx_valid}, 8'h02);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mdl_ctrl = 4'h0; prev1 = '0; prev2 = '0;
    chk("R10 ctrl after release", {4'h0, ctrl_rdata}, 8'h00);
    write_ctrl(4'hA);  // loopback both, store cleared
    run_frame(8'h3E, 8'hE3, 8'h44, 8'h44, 0, " R10 store cleared");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_normal();
    t_single_modes();
    t_all_modes();
    t_stall();
    t_clears();
    t_hw_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule